// File: doc/BRIEF.md
# T1 In-Band Loopback Code Detector

The block watches the received serial bit stream of a T1 line and reports when the far end is sending one of two in-band loopback codes. The arm code repeats four zeros followed by a one. The release code repeats two zeros followed by a one. Each code has its own tracker. A tracker compares the stream against every phase of its code and counts mismatches over fixed windows of valid bits. The tracker's status bit sets when a full window has been seen with few enough mismatches. It clears when a later window has too many.

The line clock is qualified by a valid strobe, so idle cycles do not advance anything. When the framer reports alignment, the framing bit at the start of each frame carries no code data, so it is left out of the mismatch count. A mode input lets the arm status output carry an external status bit instead of the tracker result. Any change of either output raises a one-cycle interrupt pulse. The window length and the mismatch limit are parameters. The defaults are 51,200 bits (about 33.16 ms at 1.544 Mb/s) and 512 mismatches.

Top module: `lbk_detect`

## Requirements
- R1: After reset, `arm_det`, `rel_det` and `lbk_irq` are all 0.
- R2: The arm tracker sets when a window ends with fewer than ERR_LIM mismatches against the repeating pattern 0,0,0,0,1 (a one in every fifth bit). `arm_det` rises on the second rising edge counted from the edge that samples the last valid bit of that window.
- R3: The release tracker behaves like R2 against the repeating pattern 0,0,1 and drives `rel_det`.
- R4: While a tracker is clear, a window with exactly ERR_LIM mismatches does not set it.
- R5: While a tracker is set, it stays set after every window with ERR_LIM or fewer mismatches. It clears after the first window with more than ERR_LIM mismatches.
- R6: While `frm_aligned` is 1, a valid bit that has `frm_first` = 1 is not counted as a mismatch. While `frm_aligned` is 0, that bit is counted like any other bit.
- R7: Windows are consecutive runs of WIN_LEN valid bits, counted from reset. Cycles with `bit_vld` = 0 change neither a count nor a status.
- R8: The two trackers are independent. Each evaluates the same stream against its own code only.
- R9: While `alt_sel` is 1, `arm_det` shows the value `alt_stat` had at the previous rising edge. The arm tracker keeps running underneath.
- R10: `lbk_irq` is 1 for exactly the cycles in which `arm_det` or `rel_det` differs from its value in the cycle before.
- R11: A code is detected at any phase relative to the window start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| frm_first | input | 1 | Marks the valid bit as the first bit of a frame |
| frm_aligned | input | 1 | Framer reports frame alignment |
| alt_sel | input | 1 | Routes `alt_stat` to `arm_det` |
| alt_stat | input | 1 | External status shown in alternate mode |
| arm_det | output | 1 | Arm (activate) code status |
| rel_det | output | 1 | Release (deactivate) code status |
| lbk_irq | output | 1 | One-cycle pulse on any status change |

## Verification
The bench builds the block with WIN_LEN = 60 and ERR_LIM = 2. This makes a full qualification window last a few dozen cycles, so many set, hold and clear transitions fit in a short run. It also makes an exact-limit window (two mismatches) and an over-limit window (three mismatches) easy to construct directly. A window of the wrong code still gives far more than two mismatches at every phase. As a result, the random windows separate clearly into detections and rejections.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
    localparam int unsigned ARM_PERIOD = 5;
    localparam int unsigned REL_PERIOD = 3;

    typedef struct packed {
        logic arm;
        logic rel;
        logic irq;
    } lbk_out_s;
endpackage

// File: rtl/lbk_tracker.sv
module lbk_tracker #(
    parameter int unsigned PERIOD  = 5,
    parameter int unsigned WIN_LEN = 51200,
    parameter int unsigned ERR_LIM = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    input  logic skip_bit,
    output logic det
);
    localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int unsigned WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int unsigned EW = $clog2(ERR_LIM + 2);
    localparam logic [EW-1:0] LIM = EW'(ERR_LIM);
    localparam logic [EW-1:0] SAT = EW'(ERR_LIM + 1);

    typedef struct packed {
        logic                       det;
        logic [PW-1:0]              ph;
        logic [WW-1:0]              win;
        logic [PERIOD-1:0][EW-1:0]  err;
    } trk_s;

    trk_s q, d;
    logic [PERIOD-1:0] miss;
    logic              win_end;
    logic              any_lt;
    logic              any_le;
    logic [EW-1:0]     nxt_err;

    // one comparator per phase of the code
    for (genvar r = 0; r < PERIOD; r++) begin : g_rot
        logic [PW:0] sum;
        logic [PW:0] rot;
        assign sum     = {1'b0, q.ph} + (PW+1)'(r);
        assign rot     = (sum >= (PW+1)'(PERIOD)) ? sum - (PW+1)'(PERIOD) : sum;
        assign miss[r] = bit_in ^ (rot == (PW+1)'(PERIOD - 1));
    end

    always_comb begin
        d       = q;
        win_end = bit_vld && (q.win == WW'(WIN_LEN - 1));
        any_lt  = 1'b0;
        any_le  = 1'b0;
        nxt_err = '0;
        if (bit_vld) begin
            d.ph  = (q.ph == PW'(PERIOD - 1)) ? '0 : q.ph + 1'b1;
            d.win = win_end ? '0 : q.win + 1'b1;
        end
        for (int r = 0; r < PERIOD; r++) begin
            nxt_err = q.err[r];
            if (bit_vld && !skip_bit && miss[r] && (nxt_err != SAT))
                nxt_err = nxt_err + 1'b1;
            if (nxt_err < LIM)  any_lt = 1'b1;
            if (nxt_err <= LIM) any_le = 1'b1;
            d.err[r] = win_end ? '0 : nxt_err;
        end
        if (win_end)
            d.det = q.det ? any_le : any_lt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign det = q.det;

    // R7: idle cycles leave the status alone
    a_r7_idle_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(q.det));

    // R5: status only moves at a window boundary
    a_r5_change_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        (q.det != $past(q.det)) |-> $past(win_end));
endmodule

// File: rtl/lbk_detect.sv
module lbk_detect
    import lbk_pkg::*;
#(
    parameter int unsigned WIN_LEN = 51200,
    parameter int unsigned ERR_LIM = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    input  logic frm_first,
    input  logic frm_aligned,
    input  logic alt_sel,
    input  logic alt_stat,
    output logic arm_det,
    output logic rel_det,
    output logic lbk_irq
);
    logic     skip_bit;
    logic     arm_raw;
    logic     rel_raw;
    lbk_out_s out_q, out_d;

    assign skip_bit = frm_aligned && frm_first;

    lbk_tracker #(.PERIOD(ARM_PERIOD), .WIN_LEN(WIN_LEN), .ERR_LIM(ERR_LIM)) u_arm (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .skip_bit(skip_bit), .det(arm_raw)
    );

    lbk_tracker #(.PERIOD(REL_PERIOD), .WIN_LEN(WIN_LEN), .ERR_LIM(ERR_LIM)) u_rel (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .skip_bit(skip_bit), .det(rel_raw)
    );

    always_comb begin
        out_d     = out_q;
        out_d.arm = alt_sel ? alt_stat : arm_raw;
        out_d.rel = rel_raw;
        out_d.irq = (out_d.arm != out_q.arm) || (out_d.rel != out_q.rel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign arm_det = out_q.arm;
    assign rel_det = out_q.rel;
    assign lbk_irq = out_q.irq;

    // R10: pulse exactly when an output moved
    a_r10_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_q.arm != $past(out_q.arm)) || (out_q.rel != $past(out_q.rel))) |-> out_q.irq);
    a_r10_irq_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.irq |-> ((out_q.arm != $past(out_q.arm)) || (out_q.rel != $past(out_q.rel))));

    // R9: alternate source follows the external input one edge later
    a_r9_alt_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alt_sel) |-> (out_q.arm == $past(alt_stat)));
endmodule

// File: tb/lbk_detect_test.sv
module lbk_detect_test;
    localparam int unsigned WL  = 60;
    localparam int unsigned LIM = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0, bit_vld = 1'b0, frm_first = 1'b0, frm_aligned = 1'b0;
    logic alt_sel = 1'b0, alt_stat = 1'b0;
    logic arm_det, rel_det, lbk_irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lbk_detect #(.WIN_LEN(WL), .ERR_LIM(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .frm_first(frm_first), .frm_aligned(frm_aligned),
        .alt_sel(alt_sel), .alt_stat(alt_stat),
        .arm_det(arm_det), .rel_det(rel_det), .lbk_irq(lbk_irq)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // ---------------- reference model built from the requirements ----------------
    int m_ea[5];
    int m_er[3];
    int m_cnt;
    bit m_da, m_dr, m_arm, m_rel, m_irq;

    function automatic bit code_bit(input int per, input int pos);
        return (pos % per) == (per - 1);
    endfunction

    // a tracker's new status at the end of a window: strict below to set, at most to hold
    function automatic bit decide(input bit cur, input int minerr);
        return cur ? (minerr <= LIM) : (minerr < LIM);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_ea[i]) m_ea[i] = 0;
            foreach (m_er[i]) m_er[i] = 0;
            m_cnt = 0; m_da = 0; m_dr = 0; m_arm = 0; m_rel = 0; m_irq = 0;
        end else begin
            bit na;
            na    = alt_sel ? alt_stat : m_da;
            m_irq = (na != m_arm) || (m_dr != m_rel);
            m_arm = na;
            m_rel = m_dr;
            if (bit_vld) begin
                bit counted;
                int mina, minr;
                counted = !(frm_aligned && frm_first);
                for (int r = 0; r < 5; r++)
                    if (counted && (bit_in != code_bit(5, m_cnt + r))) m_ea[r]++;
                for (int r = 0; r < 3; r++)
                    if (counted && (bit_in != code_bit(3, m_cnt + r))) m_er[r]++;
                m_cnt++;
                if (m_cnt % WL == 0) begin
                    mina = 1 << 30; minr = 1 << 30;
                    for (int r = 0; r < 5; r++) if (m_ea[r] < mina) mina = m_ea[r];
                    for (int r = 0; r < 3; r++) if (m_er[r] < minr) minr = m_er[r];
                    m_da = decide(m_da, mina);
                    m_dr = decide(m_dr, minr);
                    foreach (m_ea[i]) m_ea[i] = 0;
                    foreach (m_er[i]) m_er[i] = 0;
                end
            end
        end
    end

    // continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R9 arm_det vs model", arm_det, m_arm);
            chk("R3 rel_det vs model", rel_det, m_rel);
            chk("R10 lbk_irq vs model", lbk_irq, m_irq);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // one window of back-to-back valid bits; errors at fixed positions
    task automatic send_window(input int per, input int off, input int nerr,
                               input bit on_frame, input bit aligned);
        int epos[4];
        epos = '{10, 25, 40, 55};
        for (int i = 0; i < int'(WL); i++) begin
            bit e;
            e = 1'b0;
            for (int k = 0; k < nerr; k++) if (epos[k] == i) e = 1'b1;
            bit_vld     = 1'b1;
            bit_in      = code_bit(per, i + off) ^ e;
            frm_first   = on_frame && e;
            frm_aligned = aligned;
            @(negedge clk);
        end
        bit_vld = 1'b0; frm_first = 1'b0; frm_aligned = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int gv;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk("R1 arm_det reset", arm_det, 1'b0);
        chk("R1 rel_det reset", rel_det, 1'b0);
        chk("R1 lbk_irq reset", lbk_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 arm_det after release", arm_det, 1'b0);

        send_window(5, 0, 0, 0, 0);
        chk("R2 arm sets on clean window", arm_det, 1'b1);
        chk("R10 irq on arm set", lbk_irq, 1'b1);
        @(negedge clk);
        chk("R10 irq one cycle only", lbk_irq, 1'b0);

        send_window(5, 2, 2, 0, 0);
        chk("R5 R11 arm holds at limit, new phase", arm_det, 1'b1);
        send_window(5, 2, 3, 0, 0);
        chk("R5 arm clears above limit", arm_det, 1'b0);
        chk("R10 irq on arm clear", lbk_irq, 1'b1);
        send_window(5, 4, 2, 0, 0);
        chk("R4 exact limit does not set", arm_det, 1'b0);

        send_window(3, 1, 0, 0, 0);
        chk("R3 rel sets on clean window", rel_det, 1'b1);
        chk("R8 arm unaffected by release code", arm_det, 1'b0);

        send_window(3, 0, 3, 1, 1);
        chk("R6 framing bits excluded when aligned", rel_det, 1'b1);
        send_window(3, 0, 3, 1, 0);
        chk("R6 framing bits counted when not aligned", rel_det, 1'b0);

        // R7: idle cycles with junk do not advance the window
        repeat (30) begin
            bit_vld = 1'b0; bit_in = 1'($urandom); frm_first = 1'($urandom);
            @(negedge clk);
        end
        chk("R7 idle cycles change nothing", arm_det, 1'b0);

        alt_sel = 1'b1; alt_stat = 1'b1;
        @(negedge clk);
        chk("R9 arm shows external status", arm_det, 1'b1);
        chk("R10 irq on alternate change", lbk_irq, 1'b1);
        alt_stat = 1'b0;
        @(negedge clk);
        chk("R9 arm follows external low", arm_det, 1'b0);
        alt_sel = 1'b0;
        @(negedge clk);

        // constrained random windows with gaps, frames and mode changes
        gv = 0;
        for (int w = 0; w < 40; w++) begin
            int kind, off, rate, per;
            kind = $urandom % 3;
            off  = $urandom % 15;
            rate = (($urandom % 4) == 0) ? 8 : ($urandom % 3);
            per  = (kind == 0) ? 5 : 3;
            frm_aligned = 1'($urandom);
            for (int i = 0; i < int'(WL); i++) begin
                while (($urandom % 4) == 0) begin
                    bit_vld = 1'b0; bit_in = 1'($urandom); frm_first = 1'($urandom);
                    if (($urandom % 40) == 0) alt_sel = ~alt_sel;
                    if (($urandom % 20) == 0) alt_stat = ~alt_stat;
                    @(negedge clk);
                end
                bit_vld   = 1'b1;
                frm_first = (gv % 24) == 0;
                if (kind == 2) bit_in = 1'($urandom);
                else           bit_in = code_bit(per, i + off) ^ ((($urandom % 100) < rate) ? 1'b1 : 1'b0);
                gv++;
                @(negedge clk);
            end
        end
        bit_vld = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule